// File: doc/BRIEF.md
# Post-Reset Initialization Status Sequencer

This block decides what the chip reports about itself between reset release and the start of normal bus traffic. After reset it raises a failure indication while the built-in self-test runs. If the self-test passes, it clears the indication and reads the first words of memory through a simple word-read port. It adds those words with wrap-around arithmetic and requires the total to be zero.

A failed self-test, or a nonzero total, raises the indication again and keeps it raised until the next reset. A passing check releases a go signal that hands the bus to normal operation.

There is no dedicated failure pin. Failure is encoded on the shared burst-last and byte-enable pins as burst-last asserted with every byte lane idle. Once the block reaches normal operation, those pins carry whatever the bus unit drives.

Top module: `init_status_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the outputs are quiet: `fail_o` is 0, `bus_go_o` is 0, `rd_req` is 0, `burst_last_o` is 0 and `byte_en_o` is 0.
- R2: From the second cycle after reset release until the cycle after `bist_done` is seen, `fail_o` is 1. All pins use logical active-high values. While `fail_o` is 1, the pins show the failure code `burst_last_o`=1 and `byte_en_o`=0, whatever the bus unit drives.
- R3: `bist_done`=1 with `bist_pass`=1 clears `fail_o` on the next cycle and raises `rd_req` to start the checksum.
- R4: `bist_done`=1 with `bist_pass`=0 keeps `fail_o` at 1 from the next cycle on, and no memory read is ever requested.
- R5: The checksum reads word addresses 0 to N_WORDS-1 (eight by default) in ascending order, one word per cycle in which `rd_req` and `rd_valid` are both 1. A cycle with `rd_valid`=0 holds the address. Each word is read exactly once, and no result appears before the last word has been accepted.
- R6: If the wrap-around sum modulo 2^32 of the words read is zero, `bus_go_o` rises on the cycle after the last word is accepted, and `fail_o` stays 0.
- R7: If that sum is nonzero, `fail_o` rises on the cycle after the last word is accepted, and `bus_go_o` stays 0.
- R8: Once failure is latched, only reset leaves it: `bist_done`, `bist_pass` and `rd_valid` have no effect, and `rd_req` stays 0.
- R9: While `bus_go_o` is 1, `burst_last_o` and `byte_en_o` follow `bus_blast_i` and `bus_be_i`. Before that, those inputs do not reach the pins.
- R10: Once `bus_go_o` is 1 it stays 1 until reset, and `fail_o` and `bus_go_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_done | input | 1 | Self-test has finished (sampled in the self-test phase) |
| bist_pass | input | 1 | Self-test result, valid with `bist_done` |
| rd_req | output | 1 | Word read request to memory |
| rd_addr | output | 3 | Word address of the current read |
| rd_valid | input | 1 | Read data valid; the word is taken on this cycle |
| rd_data | input | 32 | Read data word |
| bus_blast_i | input | 1 | Burst-last value from the bus unit |
| bus_be_i | input | 2 | Byte enables from the bus unit |
| burst_last_o | output | 1 | Shared burst-last / failure pin (logical, 1 = asserted) |
| byte_en_o | output | 2 | Shared byte-enable pins (logical, 1 = lane enabled) |
| fail_o | output | 1 | Failure indication |
| bus_go_o | output | 1 | Normal bus operation may begin |

## Verification
Every cycle, the assertions check the following:
- the pin code shown whenever `fail_o` is high;
- that a latched failure never ends and never issues reads;
- that go is sticky and never coincides with failure;
- the self-test outcome transitions;
- the address ordering and stall-hold of the read stream;
- pass-through of the bus unit's pins after go.

Only the bench scenarios can show the following:
- that the checksum verdict matches the arithmetic sum of the stored words, including sums that are zero only through wrap-around;
- that the verdict appears exactly after the eighth accepted word under various stall patterns;
- the reset-quiet window.

// File: rtl/init_status_pkg.sv
package init_status_pkg;

    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_SELFTEST = 3'd1,
        ST_CHECKSUM = 3'd2,
        ST_RUN      = 3'd3,
        ST_FAILED   = 3'd4
    } init_state_e;

    typedef struct packed {
        logic done;   // final word accepted this cycle
        logic zero;   // total including that word is zero
    } sum_res_t;

    function automatic logic state_signals_fail(init_state_e s);
        return (s == ST_SELFTEST) || (s == ST_FAILED);
    endfunction

    function automatic logic state_is_run(init_state_e s);
        return s == ST_RUN;
    endfunction

endpackage

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
    import init_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bist_done,
    input  logic        bist_pass,
    input  sum_res_t    sum_res,
    output init_state_e state_o
);

    init_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RESET:    st_d = ST_SELFTEST;
            ST_SELFTEST: if (bist_done) st_d = bist_pass ? ST_CHECKSUM : ST_FAILED;
            ST_CHECKSUM: if (sum_res.done) st_d = sum_res.zero ? ST_RUN : ST_FAILED;
            ST_RUN:      st_d = ST_RUN;
            ST_FAILED:   st_d = ST_FAILED;
            default:     st_d = ST_FAILED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RESET;
        else     st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/init_sum_engine.sv
module init_sum_engine
    import init_status_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 8,
    localparam int CNT_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [CNT_W-1:0]  rd_addr,
    output sum_res_t          sum_res
);

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_next;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_word;

    assign acc_next  = acc_q + rd_data;   // wraps modulo 2^DATA_W
    assign last_word = (cnt_q == CNT_W'(N_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (rd_valid) begin
            acc_q <= acc_next;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rd_req       = active;
    assign rd_addr      = cnt_q;
    assign sum_res.done = active && rd_valid && last_word;
    assign sum_res.zero = (acc_next == '0);

endmodule

// File: rtl/init_pin_encoder.sv
module init_pin_encoder #(
    parameter int BE_W = 2
) (
    input  logic            fail,
    input  logic            run,
    input  logic            bus_blast_i,
    input  logic [BE_W-1:0] bus_be_i,
    output logic            burst_last_o,
    output logic [BE_W-1:0] byte_en_o
);

    always_comb begin
        if (fail) begin
            burst_last_o = 1'b1;      // failure code: burst-last with idle lanes
            byte_en_o    = '0;
        end else if (run) begin
            burst_last_o = bus_blast_i;
            byte_en_o    = bus_be_i;
        end else begin
            burst_last_o = 1'b0;
            byte_en_o    = '0;
        end
    end

endmodule

// File: rtl/init_status_seq.sv
module init_status_seq
    import init_status_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 8,
    parameter int BE_W    = 2,
    localparam int CNT_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_done,
    input  logic              bist_pass,
    output logic              rd_req,
    output logic [CNT_W-1:0]  rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              bus_blast_i,
    input  logic [BE_W-1:0]   bus_be_i,
    output logic              burst_last_o,
    output logic [BE_W-1:0]   byte_en_o,
    output logic              fail_o,
    output logic              bus_go_o
);

    init_state_e st_q;
    sum_res_t    sum_res;

    init_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bist_done (bist_done),
        .bist_pass (bist_pass),
        .sum_res   (sum_res),
        .state_o   (st_q)
    );

    init_sum_engine #(
        .DATA_W  (DATA_W),
        .N_WORDS (N_WORDS)
    ) u_sum (
        .clk      (clk),
        .rst      (rst),
        .active   (st_q == ST_CHECKSUM),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .sum_res  (sum_res)
    );

    assign fail_o   = state_signals_fail(st_q);
    assign bus_go_o = state_is_run(st_q);

    init_pin_encoder #(
        .BE_W (BE_W)
    ) u_pins (
        .fail         (fail_o),
        .run          (bus_go_o),
        .bus_blast_i  (bus_blast_i),
        .bus_be_i     (bus_be_i),
        .burst_last_o (burst_last_o),
        .byte_en_o    (byte_en_o)
    );

endmodule

// File: rtl/init_status_seq_chk.sv
module init_status_seq_chk
    import init_status_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int BE_W    = 2,
    parameter int CNT_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input init_state_e      state,
    input logic             bist_done,
    input logic             bist_pass,
    input logic             rd_req,
    input logic [CNT_W-1:0] rd_addr,
    input logic             rd_valid,
    input logic             bus_blast_i,
    input logic [BE_W-1:0]  bus_be_i,
    input logic             burst_last_o,
    input logic [BE_W-1:0]  byte_en_o,
    input logic             fail_o,
    input logic             bus_go_o
);

    // R2
    fail_code_chk: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (burst_last_o && byte_en_o == '0));

    // R3
    bist_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SELFTEST && bist_done && bist_pass) |=> (rd_req && !fail_o));

    // R4
    bist_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SELFTEST && bist_done && !bist_pass) |=> (state == ST_FAILED));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid && rd_addr != CNT_W'(N_WORDS - 1))
            |=> (rd_req && rd_addr == CNT_W'($past(rd_addr) + 1'b1)));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R8
    failed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAILED) |=> (state == ST_FAILED && fail_o && !rd_req));

    // R9
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        bus_go_o |-> (burst_last_o == bus_blast_i && byte_en_o == bus_be_i));

    // R10
    go_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        bus_go_o |=> bus_go_o);

    // R10
    go_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_go_o && fail_o));

endmodule

bind init_status_seq init_status_seq_chk #(
    .N_WORDS (N_WORDS),
    .BE_W    (BE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .state        (st_q),
    .bist_done    (bist_done),
    .bist_pass    (bist_pass),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_valid     (rd_valid),
    .bus_blast_i  (bus_blast_i),
    .bus_be_i     (bus_be_i),
    .burst_last_o (burst_last_o),
    .byte_en_o    (byte_en_o),
    .fail_o       (fail_o),
    .bus_go_o     (bus_go_o)
);

// File: tb/test_init_status_seq.sv
`timescale 1ns/1ps
module test_init_status_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bist_done = 1'b0;
    logic        bist_pass = 1'b0;
    logic        rd_req;
    logic [2:0]  rd_addr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        bus_blast_i = 1'b1;
    logic [1:0]  bus_be_i = 2'b11;
    logic        burst_last_o;
    logic [1:0]  byte_en_o;
    logic        fail_o;
    logic        bus_go_o;

    logic [31:0] mem [8];
    logic        stall = 1'b0;
    int          stall_mod = 0;
    int          tcnt = 0;
    int          beats = 0;
    int          addr_err = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign rd_valid = rd_req && !stall;
    assign rd_data  = mem[rd_addr];

    init_status_seq i_init_status_seq (
        .clk          (clk),
        .rst          (rst),
        .bist_done    (bist_done),
        .bist_pass    (bist_pass),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .bus_blast_i  (bus_blast_i),
        .bus_be_i     (bus_be_i),
        .burst_last_o (burst_last_o),
        .byte_en_o    (byte_en_o),
        .fail_o       (fail_o),
        .bus_go_o     (bus_go_o)
    );

    // memory stall pattern, changed away from the active edge
    always @(negedge clk) begin
        tcnt++;
        stall = (stall_mod != 0) && (tcnt % stall_mod == 0);
    end

    // read-stream monitor: accepted words must come at ascending addresses
    always @(posedge clk) begin
        if (rd_req && rd_valid) begin
            if (int'(rd_addr) != beats) addr_err++;
            beats++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<=150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_quiet(input string req);
        chk(fail_o == 1'b0 && bus_go_o == 1'b0 && rd_req == 1'b0 &&
            burst_last_o == 1'b0 && byte_en_o == 2'b00, req, "quiet outputs",
            {fail_o, bus_go_o, rd_req, burst_last_o, byte_en_o}, 64'h0);
    endtask

    task automatic chk_fail_code(input string req);
        chk(fail_o && burst_last_o && byte_en_o == 2'b00, req, "fail code",
            {fail_o, burst_last_o, byte_en_o}, 64'hC);
    endtask

    // reset, then enter self-test; bus inputs held active to show they are masked
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bist_done = 1'b0; bist_pass = 1'b0;
        bus_blast_i = 1'b1; bus_be_i = 2'b11;
        repeat (3) @(negedge clk);
        chk_quiet("R1");                 // during reset
        rst = 1'b0;
        #1 chk_quiet("R1");              // first cycle after release
        @(negedge clk);
        chk_fail_code("R2");             // self-test phase, R9 masking
    endtask

    task automatic fill_mem(input int k, input bit zero_sum);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 7; i++) begin
            mem[i] = (32'h9E3779B9 * 32'(i + 1)) ^ (32'(k) << (i * 3));
            s += mem[i];
        end
        mem[7] = zero_sum ? (32'h0 - s) : (32'h0 - s + 32'(k + 1));
    endtask

    task automatic run_bist(input int wait_cyc, input bit pass);
        for (int w = 0; w < wait_cyc; w++) begin
            @(negedge clk);
            chk_fail_code("R2");
        end
        beats = 0; addr_err = 0;
        bist_done = 1'b1; bist_pass = pass;
        @(negedge clk);
        bist_done = 1'b0; bist_pass = 1'b0;
    endtask

    // checksum phase with the expected verdict computed here
    task automatic run_checksum();
        logic [31:0] s;
        int guard;
        s = '0;
        for (int i = 0; i < 8; i++) s += mem[i];
        chk(!fail_o && rd_req, "R3", "checksum start", {fail_o, rd_req}, 64'h1);
        guard = 0;
        while (!bus_go_o && !fail_o && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(beats == 8, "R5", "words read before verdict", beats, 8);
        chk(addr_err == 0, "R5", "address order errors", addr_err, 0);
        if (s == 32'h0)
            chk(bus_go_o && !fail_o, "R6", "zero sum -> go", {bus_go_o, fail_o}, 64'h2);
        else
            chk(fail_o && !bus_go_o && burst_last_o && byte_en_o == 2'b00,
                "R7", "nonzero sum -> fail", {fail_o, bus_go_o}, 64'h2);
        repeat (5) @(negedge clk);
        if (s == 32'h0)
            chk(bus_go_o && !fail_o, "R10", "go sticky", bus_go_o, 1);
        else
            chk(fail_o && !bus_go_o && !rd_req, "R7", "fail held", fail_o, 1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = '0;

        // sweep: self-test length, stall pattern, zero / nonzero sum
        for (int k = 0; k < 12; k++) begin
            stall_mod = (k % 3 == 0) ? 0 : (k % 3 + 1);
            fill_mem(k, (k % 2) == 0);
            do_reset();
            run_bist(k % 4, 1'b1);
            run_checksum();
        end
        stall_mod = 0;

        // wrap-around: sum is 2^32, zero modulo 2^32
        for (int i = 0; i < 8; i++) mem[i] = '0;
        mem[2] = 32'h8000_0000; mem[5] = 32'h8000_0000;
        do_reset(); run_bist(1, 1'b1); run_checksum();     // R6

        // all-ones words with balancing last word
        for (int i = 0; i < 7; i++) mem[i] = 32'hFFFF_FFFF;
        mem[7] = 32'd7;
        do_reset(); run_bist(0, 1'b1); run_checksum();     // R6

        // only the last word nonzero
        for (int i = 0; i < 8; i++) mem[i] = '0;
        mem[7] = 32'd1;
        do_reset(); run_bist(2, 1'b1); run_checksum();     // R7

        // R8: latched failure ignores self-test and read inputs
        stall_mod = 2;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            bist_done = c[0]; bist_pass = 1'b1;
            #1 chk(fail_o && !bus_go_o && !rd_req, "R8", "failure latched",
                   {fail_o, bus_go_o, rd_req}, 64'h4);
        end
        bist_done = 1'b0; stall_mod = 0;

        // R4: self-test failure, no reads ever
        do_reset();
        run_bist(3, 1'b0);
        chk_fail_code("R4");
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            bist_done = 1'b1; bist_pass = 1'b1;
        end
        bist_done = 1'b0;
        chk(fail_o && beats == 0 && !bus_go_o, "R4", "no reads after bist fail",
            beats, 0);

        // R9: pass-through of every bus pin pattern after go
        fill_mem(99, 1'b1);
        do_reset(); run_bist(0, 1'b1); run_checksum();
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            bus_blast_i = v[2]; bus_be_i = v[1:0];
            #1 chk(burst_last_o == v[2] && byte_en_o == v[1:0], "R9", "pin pass-through",
                   {burst_last_o, byte_en_o}, 64'(v));
        end

        // reset leaves RUN back to the quiet state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_quiet("R1");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule